// File: doc/BRIEF.md
# UART control and interrupt register block

This block is the software-facing side of a simple serial port. A processor reaches it through a word-indexed register interface. Through this interface it sets up the port, reads and writes data bytes, and manages four level-sensitive interrupt lines. Bytes written to the transmit-data register enter a transmit queue. The serializer drains that queue through a pop interface. Bytes coming from the receiver are held in a single-entry holding register until software reads them.

The block keeps the transmit queue fill level and the receive holding state. From these it raises pending interrupt flags for the transmit watermark, receive watermark, transmit-drained and receive-overrun events. Each pending flag can be cleared by writing a one to it, and forced by writing to a test register. An interrupt line is high while its pending flag and its mask bit are both set. Line-level framing, parity, loopback and noise filtering belong to other blocks.

Top module: `uart_csr_ctrl`

## Requirements
- R1: The register index is the byte address shifted right by two. The map is: 0 pending, 1 mask, 2 force, 3 config, 4 status, 5 receive data, 6 transmit data, 7 queue config, 8 queue status, 9 override, 10 line value, 11 timeout. Override and timeout are plain read/write registers. Indices 12 and above read zero and ignore writes.
- R2: Interrupt bits are ordered as follows: bit 0 transmit watermark, bit 1 receive watermark, bit 2 transmit drained, bit 3 receive overrun. Each output line equals its pending bit AND its mask bit.
- R3: Writing the pending register clears each bit written as one. Writing the force register sets each bit written as one in the pending register. The force register reads zero.
- R4: A write to transmit data pushes bits [7:0] into the queue. When config bit 0 (transmit enable) is set, the pop interface presents the bytes in write order. When that bit is clear, it presents nothing. Queue status bits [LVL_W-1:0] hold the fill level.
- R5: A push into a full queue is dropped, and the level stays at the depth. Status bit 0 (full) is one exactly when the level equals the depth.
- R6: After an accepted push, the transmit watermark pending bit is set if the level is at or above the threshold in queue config bits [8+LVL_W-1:8]. After a pop, it is cleared if the level is below that threshold.
- R7: When the level drops to zero, the transmit-drained pending bit is set. Status bit 1 (empty) is one exactly when the level is zero.
- R8: Writing queue config with bit 1 set forces the level to zero. That bit reads back as zero.
- R9: While config bit 1 (receive enable) is set, an arriving byte is stored. It also clears status bit 2 (receive idle) and status bit 3 (receive empty). A read of receive data while receive is enabled sets both bits again. While receive is disabled, arriving bytes are ignored.
- R10: An accepted byte sets the receive watermark pending bit when one exceeds the threshold in queue config bits [4:2].
- R11: A byte accepted while receive empty is clear sets the receive overrun pending bit and replaces the held byte.
- R12: Writes to status, receive data, queue status and line value have no effect. Line value and transmit data read zero.
- R13: After reset, the pending and mask registers are zero and the level is zero. Status reads 0xE: empty, receive idle and receive empty set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read strobe |
| tx_pop_i | input | 1 | Serializer takes the head byte |
| tx_valid_o | output | 1 | Head byte available and transmit enabled |
| tx_data_o | output | 8 | Head byte of the transmit queue |
| rx_valid_i | input | 1 | Receiver delivers a byte |
| rx_data_i | input | 8 | Received byte |
| irq_tx_wm_o | output | 1 | Transmit watermark interrupt |
| irq_rx_wm_o | output | 1 | Receive watermark interrupt |
| irq_tx_empty_o | output | 1 | Transmit drained interrupt |
| irq_rx_ovf_o | output | 1 | Receive overrun interrupt |

## Verification
The bench builds the block with an eight-entry transmit queue, so ten writes are enough to fill it and try two pushes past the top. The drop and the full flag then show up within a short directed test. The level field is four bits wide at that depth, so the watermark threshold of three sits in the middle of the range. Both the setting crossing on push and the clearing crossing on pop are reached with a handful of bytes.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
    localparam int unsigned IRQ_N = 4;

    localparam int unsigned IRQ_TXWM  = 0;
    localparam int unsigned IRQ_RXWM  = 1;
    localparam int unsigned IRQ_TXMT  = 2;
    localparam int unsigned IRQ_RXOVF = 3;

    localparam int unsigned REG_PEND  = 0;
    localparam int unsigned REG_MASK  = 1;
    localparam int unsigned REG_FORCE = 2;
    localparam int unsigned REG_CFG   = 3;
    localparam int unsigned REG_STAT  = 4;
    localparam int unsigned REG_RXD   = 5;
    localparam int unsigned REG_TXD   = 6;
    localparam int unsigned REG_QCFG  = 7;
    localparam int unsigned REG_QSTAT = 8;
    localparam int unsigned REG_OVR   = 9;
    localparam int unsigned REG_LINE  = 10;
    localparam int unsigned REG_TMO   = 11;

    localparam int unsigned CFG_TX_EN    = 0;
    localparam int unsigned CFG_RX_EN    = 1;
    localparam int unsigned QCFG_TX_CLR  = 1;
    localparam int unsigned QCFG_RX_THR  = 2;
    localparam int unsigned QCFG_TX_THR  = 8;
endpackage

// File: rtl/uart_txq.sv
module uart_txq #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    input  logic              clear_i,
    input  logic [LVL_W-1:0]  thr_i,
    output logic [LVL_W-1:0]  level_o,
    output logic [DATA_W-1:0] head_o,
    output logic              wm_set_o,
    output logic              wm_clr_o,
    output logic              empty_evt_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [LVL_W-1:0] level;
    } txq_st_t;

    txq_st_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        push_ok = push_i && !clear_i && (st_q.level != LVL_W'(DEPTH));
        pop_ok  = pop_i && !clear_i && (st_q.level != '0);
        if (clear_i) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wptr = ptr_inc(st_q.wptr);
            if (pop_ok)  st_d.rptr = ptr_inc(st_q.rptr);
            st_d.level = st_q.level + LVL_W'(push_ok) - LVL_W'(pop_ok);
        end
        wm_set_o    = push_ok && (st_d.level >= thr_i);
        wm_clr_o    = (clear_i || pop_ok) && (st_d.level < thr_i);
        empty_evt_o = (clear_i || pop_ok) && (st_q.level != '0) && (st_d.level == '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_ff @(posedge clk_i) begin
        if (push_ok) mem_q[st_q.wptr] <= push_data_i;
    end

    assign level_o = st_q.level;
    assign head_o  = mem_q[st_q.rptr];

    assert_level_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_o <= LVL_W'(DEPTH));
    assert_full_push_dropped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !pop_i && !clear_i && level_o == LVL_W'(DEPTH)) |=> level_o == LVL_W'(DEPTH));
    assert_clear_zeroes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> level_o == '0);
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned THR_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              accept_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              read_i,
    input  logic [THR_W-1:0]  thr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              idle_o,
    output logic              empty_o,
    output logic              wm_evt_o,
    output logic              ovf_evt_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              idle;
        logic              empty;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (accept_i) begin
            st_d.data  = byte_i;
            st_d.idle  = 1'b0;
            st_d.empty = 1'b0;
        end else if (read_i) begin
            st_d.idle  = 1'b1;
            st_d.empty = 1'b1;
        end
        wm_evt_o  = accept_i && (THR_W'(1) > thr_i);
        ovf_evt_o = accept_i && !st_q.empty;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{data: '0, idle: 1'b1, empty: 1'b1};
        else         st_q <= st_d;
    end

    assign data_o  = st_q.data;
    assign idle_o  = st_q.idle;
    assign empty_o = st_q.empty;

    assert_byte_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_i |=> (!empty_o && !idle_o && data_o == $past(byte_i)));
    assert_read_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (read_i && !accept_i) |=> (empty_o && idle_o));
endmodule

// File: rtl/uart_irq_bank.sv
module uart_irq_bank #(
    parameter int unsigned N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] w1c_i,
    input  logic [N-1:0] force_i,
    input  logic [N-1:0] hw_set_i,
    input  logic [N-1:0] hw_clr_i,
    input  logic [N-1:0] enable_i,
    output logic [N-1:0] state_o,
    output logic [N-1:0] irq_o
);
    logic [N-1:0] state_d, state_q;

    always_comb begin
        state_d = (state_q & ~w1c_i & ~hw_clr_i) | force_i | hw_set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign state_o = state_q;
    assign irq_o   = state_q & enable_i;

    for (genvar k = 0; k < N; k++) begin : g_chk
        assert_force_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            force_i[k] |=> state_o[k]);
        assert_w1c_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (w1c_i[k] && !force_i[k] && !hw_set_i[k]) |=> !state_o[k]);
    end
endmodule

// File: rtl/uart_csr_ctrl.sv
module uart_csr_ctrl
    import uart_csr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned TXQ_DEPTH = 32,
    parameter int unsigned RX_THR_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic              tx_pop_i,
    output logic              tx_valid_o,
    output logic [7:0]        tx_data_o,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_data_i,
    output logic              irq_tx_wm_o,
    output logic              irq_rx_wm_o,
    output logic              irq_tx_empty_o,
    output logic              irq_rx_ovf_o
);
    localparam int unsigned LVL_W = $clog2(TXQ_DEPTH + 1);
    localparam int unsigned IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [IRQ_N-1:0]    irq_en;
        logic [31:0]         cfg;
        logic [RX_THR_W-1:0] rx_thr;
        logic [LVL_W-1:0]    tx_thr;
        logic [31:0]         ovr;
        logic [31:0]         tmo;
    } csr_t;

    csr_t csr_d, csr_q;

    logic [IDX_W-1:0] idx;
    logic             wr, rd;
    logic             unused_addr;
    logic             push, tx_clear, pop, rx_accept, rx_read;
    logic [LVL_W-1:0] level;
    logic             wm_set, wm_clr, empty_evt;
    logic [7:0]       rx_byte;
    logic             rx_idle, rx_empty, rx_wm_evt, rx_ovf_evt;
    logic [IRQ_N-1:0] w1c, force_bits, hw_set, hw_clr, irq_state, irq_vec;
    logic [3:0]       stat;

    assign idx         = addr_i[ADDR_W-1:2];
    assign unused_addr = ^addr_i[1:0];
    assign wr          = req_i && we_i;
    assign rd          = req_i && !we_i;

    always_comb begin
        csr_d = csr_q;
        if (wr) begin
            case (idx)
                IDX_W'(REG_MASK): csr_d.irq_en = wdata_i[IRQ_N-1:0];
                IDX_W'(REG_CFG):  csr_d.cfg    = wdata_i;
                IDX_W'(REG_QCFG): begin
                    csr_d.rx_thr = wdata_i[QCFG_RX_THR +: RX_THR_W];
                    csr_d.tx_thr = wdata_i[QCFG_TX_THR +: LVL_W];
                end
                IDX_W'(REG_OVR):  csr_d.ovr = wdata_i;
                IDX_W'(REG_TMO):  csr_d.tmo = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) csr_q <= '0;
        else         csr_q <= csr_d;
    end

    assign push       = wr && (idx == IDX_W'(REG_TXD));
    assign tx_clear   = wr && (idx == IDX_W'(REG_QCFG)) && wdata_i[QCFG_TX_CLR];
    assign pop        = tx_pop_i && csr_q.cfg[CFG_TX_EN];
    assign rx_accept  = rx_valid_i && csr_q.cfg[CFG_RX_EN];
    assign rx_read    = rd && (idx == IDX_W'(REG_RXD)) && csr_q.cfg[CFG_RX_EN];
    assign tx_valid_o = csr_q.cfg[CFG_TX_EN] && (level != '0);

    uart_txq #(.DEPTH(TXQ_DEPTH), .DATA_W(8)) u_txq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (push),
        .push_data_i (wdata_i[7:0]),
        .pop_i       (pop),
        .clear_i     (tx_clear),
        .thr_i       (csr_q.tx_thr),
        .level_o     (level),
        .head_o      (tx_data_o),
        .wm_set_o    (wm_set),
        .wm_clr_o    (wm_clr),
        .empty_evt_o (empty_evt)
    );

    uart_rx_hold #(.DATA_W(8), .THR_W(RX_THR_W)) u_rx (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .accept_i  (rx_accept),
        .byte_i    (rx_data_i),
        .read_i    (rx_read),
        .thr_i     (csr_q.rx_thr),
        .data_o    (rx_byte),
        .idle_o    (rx_idle),
        .empty_o   (rx_empty),
        .wm_evt_o  (rx_wm_evt),
        .ovf_evt_o (rx_ovf_evt)
    );

    always_comb begin
        w1c        = (wr && idx == IDX_W'(REG_PEND))  ? wdata_i[IRQ_N-1:0] : '0;
        force_bits = (wr && idx == IDX_W'(REG_FORCE)) ? wdata_i[IRQ_N-1:0] : '0;
        hw_set            = '0;
        hw_set[IRQ_TXWM]  = wm_set;
        hw_set[IRQ_RXWM]  = rx_wm_evt;
        hw_set[IRQ_TXMT]  = empty_evt;
        hw_set[IRQ_RXOVF] = rx_ovf_evt;
        hw_clr            = '0;
        hw_clr[IRQ_TXWM]  = wm_clr;
    end

    uart_irq_bank #(.N(IRQ_N)) u_irq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .w1c_i    (w1c),
        .force_i  (force_bits),
        .hw_set_i (hw_set),
        .hw_clr_i (hw_clr),
        .enable_i (csr_q.irq_en),
        .state_o  (irq_state),
        .irq_o    (irq_vec)
    );

    assign irq_tx_wm_o    = irq_vec[IRQ_TXWM];
    assign irq_rx_wm_o    = irq_vec[IRQ_RXWM];
    assign irq_tx_empty_o = irq_vec[IRQ_TXMT];
    assign irq_rx_ovf_o   = irq_vec[IRQ_RXOVF];

    assign stat = {rx_empty, rx_idle, (level == '0), (level == LVL_W'(TXQ_DEPTH))};

    always_comb begin
        rdata_o = '0;
        if (rd) begin
            case (idx)
                IDX_W'(REG_PEND):  rdata_o = 32'(irq_state);
                IDX_W'(REG_MASK):  rdata_o = 32'(csr_q.irq_en);
                IDX_W'(REG_CFG):   rdata_o = csr_q.cfg;
                IDX_W'(REG_STAT):  rdata_o = 32'(stat);
                IDX_W'(REG_RXD):   rdata_o = 32'(rx_byte);
                IDX_W'(REG_QCFG):  rdata_o = (32'(csr_q.tx_thr) << QCFG_TX_THR)
                                           | (32'(csr_q.rx_thr) << QCFG_RX_THR);
                IDX_W'(REG_QSTAT): rdata_o = 32'(level);
                IDX_W'(REG_OVR):   rdata_o = csr_q.ovr;
                IDX_W'(REG_TMO):   rdata_o = csr_q.tmo;
                default:           rdata_o = '0;
            endcase
        end
    end

    assert_unmapped_inert_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr && idx > IDX_W'(REG_TMO)) |=> $stable(csr_q));
    assert_masked_line_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_q.irq_en == '0) |-> (irq_vec == '0));
endmodule

// File: tb/uart_csr_ctrl_test.sv
module uart_csr_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tx_pop = 1'b0, tx_valid;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        i_txwm, i_rxwm, i_txmt, i_rxovf;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    uart_csr_ctrl #(.ADDR_W(6), .TXQ_DEPTH(8), .RX_THR_W(3)) uut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .tx_pop_i(tx_pop), .tx_valid_o(tx_valid),
        .tx_data_o(tx_data), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
        .irq_tx_wm_o(i_txwm), .irq_rx_wm_o(i_rxwm), .irq_tx_empty_o(i_txmt),
        .irq_rx_ovf_o(i_rxovf)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", rq, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk); req = 1'b1; we = 1'b1; addr = 6'(idx * 4); wdata = d;
        @(negedge clk); req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] v);
        @(negedge clk); req = 1'b1; we = 1'b0; addr = 6'(idx * 4);
        #1 v = rdata;
        @(negedge clk); req = 1'b0;
    endtask

    task automatic rd_chk(input string rq, input int idx, input logic [31:0] exp);
        logic [31:0] v;
        rd(idx, v);
        chk(rq, v, exp);
    endtask

    task automatic pop_byte(output logic [7:0] b, output logic vld);
        @(negedge clk); tx_pop = 1'b1;
        #1 b = tx_data; vld = tx_valid;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    function automatic logic [31:0] irq_pins();
        return {28'd0, i_rxovf, i_txmt, i_rxwm, i_txwm};
    endfunction

    task automatic t_reset;
        chk("R13 pend", 32'(irq_pins()), 32'h0);
        rd_chk("R13 pending reg", 0, 32'h0);
        rd_chk("R13 status", 4, 32'hE);
        rd_chk("R13 queue level", 8, 32'h0);
        chk("R13 tx_valid", 32'(tx_valid), 32'h0);
    endtask

    task automatic t_map;
        wr(9, 32'hA5A5_0001);
        rd_chk("R1 override rw", 9, 32'hA5A5_0001);
        wr(11, 32'h0000_BEEF);
        rd_chk("R1 timeout rw", 11, 32'h0000_BEEF);
        @(negedge clk); req = 1'b1; we = 1'b1; addr = 6'h27; wdata = 32'h1234;
        @(negedge clk); req = 1'b0; we = 1'b0;
        rd_chk("R1 low address bits ignored", 9, 32'h1234);
        wr(12, 32'hFFFF_FFFF);
        wr(15, 32'hFFFF_FFFF);
        rd_chk("R1 unmapped reads zero", 12, 32'h0);
        rd_chk("R1 unmapped reads zero", 15, 32'h0);
        rd_chk("R1 unmapped write no effect cfg", 3, 32'h0);
        rd_chk("R1 unmapped write no effect mask", 1, 32'h0);
    endtask

    task automatic t_irq;
        wr(1, 32'hF);
        wr(2, 32'h5);
        rd_chk("R3 force sets pending", 0, 32'h5);
        chk("R2 lines follow pending&mask", irq_pins(), 32'h5);
        rd_chk("R3 force reads zero", 2, 32'h0);
        wr(0, 32'h1);
        rd_chk("R3 w1c clears one bit", 0, 32'h4);
        wr(1, 32'h0);
        chk("R2 masked lines low", irq_pins(), 32'h0);
        wr(1, 32'h4);
        chk("R2 single mask bit", irq_pins(), 32'h4);
        wr(0, 32'hF);
        rd_chk("R3 w1c clears all", 0, 32'h0);
        wr(1, 32'hF);
    endtask

    task automatic t_tx;
        logic [7:0] b; logic v;
        wr(7, 32'h300);
        wr(6, 32'h111);
        wr(6, 32'h22);
        rd_chk("R6 below threshold no watermark", 0, 32'h0);
        wr(6, 32'h33);
        rd_chk("R6 watermark at threshold", 0, 32'h1);
        rd_chk("R4 level three", 8, 32'h3);
        rd_chk("R7 status not empty", 4, 32'hC);
        pop_byte(b, v);
        chk("R4 pop ignored while tx disabled", 32'(v), 32'h0);
        rd_chk("R4 level kept while disabled", 8, 32'h3);
        wr(3, 32'h1);
        pop_byte(b, v);
        chk("R4 first byte", 32'(b), 32'h11);
        rd_chk("R6 watermark cleared below threshold", 0, 32'h0);
        pop_byte(b, v);
        chk("R4 second byte", 32'(b), 32'h22);
        pop_byte(b, v);
        chk("R4 third byte", 32'(b), 32'h33);
        rd_chk("R7 drained sets pending", 0, 32'h4);
        rd_chk("R7 status empty", 4, 32'hE);
        chk("R4 nothing to pop", 32'(tx_valid), 32'h0);
        wr(0, 32'hF);
        wr(3, 32'h0);
    endtask

    task automatic t_full;
        logic [7:0] b; logic v;
        for (int i = 0; i < 10; i++) wr(6, 32'(8'h40 + i));
        rd_chk("R5 level saturates", 8, 32'h8);
        rd_chk("R5 full flag", 4, 32'hD);
        wr(3, 32'h1);
        for (int i = 0; i < 8; i++) begin
            pop_byte(b, v);
            chk("R5 kept bytes in order", {23'd0, v, b}, {23'd0, 1'b1, 8'(8'h40 + i)});
        end
        chk("R5 dropped bytes absent", 32'(tx_valid), 32'h0);
        rd_chk("R6 R7 pending after drain", 0, 32'h4);
        wr(0, 32'hF);
        wr(3, 32'h0);
    endtask

    task automatic t_clr;
        logic [7:0] b; logic v;
        for (int i = 0; i < 4; i++) wr(6, 32'(8'h70 + i));
        rd_chk("R6 watermark before clear", 0, 32'h1);
        wr(7, 32'h302);
        rd_chk("R8 clear zeroes level", 8, 32'h0);
        rd_chk("R8 clear bit reads zero", 7, 32'h300);
        rd_chk("R8 R7 clear drains", 0, 32'h4);
        wr(6, 32'h99);
        wr(3, 32'h1);
        pop_byte(b, v);
        chk("R8 queue restarts at head", {23'd0, v, b}, {23'd0, 1'b1, 8'h99});
        wr(0, 32'hF);
        wr(3, 32'h0);
    endtask

    task automatic t_rx;
        send_rx(8'h5A);
        rd_chk("R9 byte ignored when rx disabled", 4, 32'hE);
        rd_chk("R9 no pending when disabled", 0, 32'h0);
        wr(3, 32'h2);
        send_rx(8'h5A);
        rd_chk("R9 rx flags cleared", 4, 32'h2);
        rd_chk("R10 watermark with threshold zero", 0, 32'h2);
        rd_chk("R9 byte stored", 5, 32'h5A);
        rd_chk("R9 read restores flags", 4, 32'hE);
        wr(0, 32'hF);
        wr(7, 32'h304);
        send_rx(8'h3C);
        rd_chk("R10 no watermark at threshold one", 0, 32'h0);
        rd_chk("R9 second byte", 5, 32'h3C);
    endtask

    task automatic t_ovf;
        send_rx(8'h01);
        rd_chk("R11 no overrun on first byte", 0, 32'h0);
        send_rx(8'h02);
        rd_chk("R11 overrun pending", 0, 32'h8);
        chk("R11 overrun line", irq_pins(), 32'h8);
        rd_chk("R11 byte replaced", 5, 32'h02);
        wr(0, 32'hF);
    endtask

    task automatic t_ro;
        wr(4, 32'hFFFF);
        wr(5, 32'hFF);
        wr(8, 32'hFF);
        wr(10, 32'hFF);
        rd_chk("R12 status ignores write", 4, 32'hE);
        rd_chk("R12 rxd ignores write", 5, 32'h02);
        rd_chk("R12 qstat ignores write", 8, 32'h0);
        rd_chk("R12 line reads zero", 10, 32'h0);
        wr(6, 32'h55);
        rd_chk("R12 txd reads zero", 6, 32'h0);
        rd_chk("R12 txd write pushed", 8, 32'h1);
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_irq();
        t_tx();
        t_full();
        t_clr();
        t_rx();
        t_ovf();
        t_ro();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end
endmodule